// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock using an n-bit shift register with XOR feedback. The feedback taps come straight from the divisor polynomial with its leading term left out. All arithmetic is modulo 2, so every addition is an XOR. The register width (`CRC_W`) and the tap pattern (`POLY`) are parameters. The defaults are 16 bits with the divisor X^16 + X^12 + X^5 + 1, so `POLY` = 16'h1021. A 5-bit setting with divisor 110101 (`POLY` = 5'b10101) is also exercised.

A single register serves both directions. A frame begins with a `start` pulse, which clears the register and latches `rx_mode`. The message then enters most significant bit first, one bit on each cycle that `din_valid` is high. `msg_end` is raised together with the last valid bit.

- **Transmit (`rx_mode` = 0):** after the last bit the register holds the remainder. The block shifts that remainder out on `fcs_bit`, MSB first, feeding zeros into the register, with `fcs_valid` high for exactly `CRC_W` cycles.
- **Receive (`rx_mode` = 1):** the message is followed by its appended check bits, and `msg_end` marks the last check bit. The block then reports `result_valid`, with `check_pass` high when the register is all zeros.

The controller has four states:

- **ST_IDLE:** the state after reset. Only `start` leaves it (transition *go*, to ST_ACCUM).
- **ST_ACCUM:** valid bits are folded into the register. If a valid bit arrives with `msg_end`, the controller takes transition *tx_done* to ST_EMIT in transmit mode, or *rx_done* to ST_DONE in receive mode.
- **ST_EMIT:** the remainder is shifted out. After the last of the `CRC_W` bits the controller takes transition *emitted* to ST_DONE.
- **ST_DONE:** the state holds until `start`.

From any state, `start` takes transition *restart* to ST_ACCUM, and it has priority over every other input.

Top module: `serial_crc_engine`

## Requirements
- R1: After reset, with no `start`, `fcs_valid`, `result_valid` and `check_pass` are all 0.
- R2: `start` clears the register, so a frame's result does not depend on any earlier frame. `rx_mode` is sampled only in the cycle `start` is high.
- R3: In ST_ACCUM, each bit with `din_valid`=1 is folded in MSB first. Cycles with `din_valid`=0 change nothing, and `msg_end` is ignored on those cycles.
- R4: In transmit mode, in the cycle after the last message bit, `fcs_valid` rises and stays high for exactly `CRC_W` cycles. It is never high together with `result_valid`.
- R5: During those cycles, `fcs_bit` presents the remainder of M·X^n divided by the divisor, most significant bit first. `din` has no effect on it.
- R6: In receive mode, in the cycle after the last check bit, `result_valid` is 1. `check_pass` is 1 exactly when message plus appended remainder leaves an all-zero register. `check_pass` is never 1 without `result_valid`.
- R7: In receive mode, a frame with any single bit inverted gives `check_pass` = 0.
- R8: ST_DONE holds (`result_valid` stays 1) until `start`. A transmit frame ends in ST_DONE with `check_pass` = 0.
- R9: `start` overrides every state, including in mid-frame. In the next cycle `fcs_valid` and `result_valid` are 0, and the new frame is computed from a cleared register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear register and begin a frame |
| rx_mode | input | 1 | 1 = check received frame, 0 = generate; sampled with start |
| din | input | 1 | Serial data bit |
| din_valid | input | 1 | Qualifies din |
| msg_end | input | 1 | Marks the last bit of the frame input |
| fcs_bit | output | 1 | Serial remainder output, MSB first |
| fcs_valid | output | 1 | fcs_bit is a remainder bit |
| result_valid | output | 1 | Frame finished (ST_DONE) |
| check_pass | output | 1 | Received frame left an all-zero register |

## Verification
Every cycle, the assertions check the following:
- `fcs_valid` and `result_valid` are never high together.
- `fcs_valid` never stays high for more than `CRC_W` cycles in a row.
- `check_pass` only appears with `result_valid`.
- ST_DONE holds until `start`.
- `start` always drops both status outputs in the next cycle.

Only the bench's scenarios can show that the shifted-out bits equal the arithmetic remainder. The same holds for a clean received frame passing, a frame with one inverted bit failing, and gaps and stray `din` changing nothing. To show these, it sweeps every 10-bit message on the 5-bit configuration and a few hundred random messages on the 16-bit one.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_EMIT  = 2'd2,
        ST_DONE  = 2'd3
    } crc_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_STEP  = 2'd2,
        OP_SHIFT = 2'd3
    } reg_op_e;

endpackage

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
    import crc_pkg::*;
#(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_op_e      op,
    input  logic         din,
    output logic [W-1:0] rem
);

    logic         fb;
    logic [W-1:0] stepped;

    assign fb = rem[W-1] ^ din;

    // Bit 0 takes the feedback only when the divisor has an X^0 term.
    generate
        if (POLY[0]) begin : g_tap0
            assign stepped[0] = fb;
        end else begin : g_notap0
            assign stepped[0] = 1'b0;
        end

        for (genvar i = 1; i < W; i++) begin : g_bit
            if (POLY[i]) begin : g_tap
                assign stepped[i] = rem[i-1] ^ fb;
            end else begin : g_plain
                assign stepped[i] = rem[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: rem <= '0;
                OP_STEP:  rem <= stepped;
                OP_SHIFT: rem <= {rem[W-2:0], 1'b0};
                default:  rem <= rem;
            endcase
        end
    end

endmodule

// File: rtl/crc_emit_counter.sv
module crc_emit_counter #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(W - 1));

endmodule

// File: rtl/crc_ctrl_fsm.sv
module crc_ctrl_fsm
    import crc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    rx_mode,
    input  logic    din_valid,
    input  logic    msg_end,
    input  logic    emit_last,
    input  logic    rem_zero,
    output reg_op_e op,
    output logic    cnt_clear,
    output logic    cnt_inc,
    output logic    fcs_valid,
    output logic    result_valid,
    output logic    check_pass
);

    crc_state_e state_q, state_d;
    logic       rx_q;

    // State register and latched direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rx_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                rx_q <= rx_mode;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ACCUM;                         // restart / go
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ACCUM: begin
                    if (din_valid && msg_end) begin
                        state_d = rx_q ? ST_DONE : ST_EMIT; // rx_done / tx_done
                    end
                end
                ST_EMIT: begin
                    if (emit_last) begin
                        state_d = ST_DONE;              // emitted
                    end
                end
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath controls
    always_comb begin
        op           = OP_HOLD;
        cnt_clear    = 1'b0;
        cnt_inc      = 1'b0;
        fcs_valid    = 1'b0;
        result_valid = 1'b0;
        check_pass   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCUM: begin
                if (din_valid) begin
                    op = OP_STEP;
                end
                cnt_clear = 1'b1;
            end
            ST_EMIT: begin
                op        = OP_SHIFT;
                cnt_inc   = 1'b1;
                fcs_valid = 1'b1;
            end
            ST_DONE: begin
                result_valid = 1'b1;
                check_pass   = rx_q && rem_zero;
            end
            default: ;
        endcase
        if (start) begin
            op        = OP_CLEAR;
            cnt_clear = 1'b1;
        end
    end

endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine
    import crc_pkg::*;
#(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rx_mode,
    input  logic din,
    input  logic din_valid,
    input  logic msg_end,
    output logic fcs_bit,
    output logic fcs_valid,
    output logic result_valid,
    output logic check_pass
);

    reg_op_e          op;
    logic [CRC_W-1:0] rem;
    logic             cnt_clear;
    logic             cnt_inc;
    logic             emit_last;
    logic             emit_on;

    crc_lfsr_core #(.W(CRC_W), .POLY(POLY)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .din   (din),
        .rem   (rem)
    );

    crc_emit_counter #(.W(CRC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .last  (emit_last)
    );

    crc_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rx_mode      (rx_mode),
        .din_valid    (din_valid),
        .msg_end      (msg_end),
        .emit_last    (emit_last),
        .rem_zero     (rem == '0),
        .op           (op),
        .cnt_clear    (cnt_clear),
        .cnt_inc      (cnt_inc),
        .fcs_valid    (emit_on),
        .result_valid (result_valid),
        .check_pass   (check_pass)
    );

    assign fcs_valid = emit_on;
    assign fcs_bit   = emit_on & rem[CRC_W-1];

endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker #(
    parameter int W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic fcs_valid,
    input logic result_valid,
    input logic check_pass
);

    localparam int RW = $clog2(W + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (fcs_valid) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R4
    emit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fcs_valid && result_valid));

    // R4
    emit_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RW'(W)) |-> !fcs_valid);

    // R6
    pass_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        check_pass |-> result_valid);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !start) |=> result_valid);

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!fcs_valid && !result_valid));

endmodule

bind serial_crc_engine crc_engine_checker #(.W(CRC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .fcs_valid    (fcs_valid),
    .result_valid (result_valid),
    .check_pass   (check_pass)
);

// File: tb/serial_crc_engine_tb.sv
module crc_cfg_bench #(
    parameter int           W       = 5,
    parameter logic [W-1:0] POLY    = 5'b10101,
    parameter int           LEN     = 10,
    parameter int           NUM     = 1024,
    parameter bit           EXHAUST = 1'b1
) (
    input logic clk,
    input logic rst_n
);

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic start = 1'b0, rx_mode = 1'b0, din = 1'b0, din_valid = 1'b0, msg_end = 1'b0;
    logic fcs_bit, fcs_valid, result_valid, check_pass;

    serial_crc_engine #(.CRC_W(W), .POLY(POLY)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode),
        .din(din), .din_valid(din_valid), .msg_end(msg_end),
        .fcs_bit(fcs_bit), .fcs_valid(fcs_valid),
        .result_valid(result_valid), .check_pass(check_pass)
    );

    // Long division of M * X^W by the full divisor, modulo 2
    function automatic logic [63:0] model_rem(input logic [63:0] m, input int len);
        logic [63:0] t, fullp;
        t     = m << W;
        fullp = (64'd1 << W) | 64'(POLY);
        for (int i = len + W - 1; i >= W; i--) begin
            if (t[i]) t = t ^ (fullp << (i - W));
        end
        return t & ((64'd1 << W) - 1);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s (W=%0d): actual %0h expected %0h", req, W, act, exp);
        end
    endtask

    task automatic begin_frame(input logic rx);
        start = 1'b1; rx_mode = rx; din_valid = 1'b0; msg_end = 1'b0;
        @(negedge clk);
        start = 1'b0; rx_mode = ~rx;   // R2: later rx_mode values are ignored
    endtask

    task automatic feed(input logic [63:0] v, input int len, input bit gaps);
        for (int i = len - 1; i >= 0; i--) begin
            if (gaps && (i % 3 == 0)) begin
                din = 1'($urandom); din_valid = 1'b0; msg_end = 1'b1;  // R3 idle cycle
                @(negedge clk);
            end
            din = v[i]; din_valid = 1'b1; msg_end = (i == 0);
            @(negedge clk);
        end
        din_valid = 1'b0; msg_end = 1'b0;
    endtask

    task automatic tx_frame(input logic [63:0] m, input bit gaps);
        logic [63:0] r;
        r = model_rem(m, LEN);
        begin_frame(1'b0);
        feed(m, LEN, gaps);
        for (int k = W - 1; k >= 0; k--) begin
            check("R4 fcs_valid during emit", fcs_valid, 1);
            check("R5 fcs_bit value", fcs_bit, r[k]);
            din = 1'($urandom);
            @(negedge clk);
        end
        check("R4 fcs_valid drops", fcs_valid, 0);
        check("R8 tx ends done, no pass", {result_valid, check_pass}, 2'b10);
    endtask

    task automatic rx_frame(input logic [63:0] m, input int flip, input bit gaps);
        logic [63:0] f;
        f = (m << W) | model_rem(m, LEN);
        if (flip >= 0) f = f ^ (64'd1 << flip);
        begin_frame(1'b1);
        feed(f, LEN + W, gaps);
        check("R6 result_valid", result_valid, 1);
        if (flip >= 0) check("R7 corrupted frame rejected", check_pass, 0);
        else           check("R6 clean frame passes", check_pass, 1);
    endtask

    initial begin
        logic [63:0] m;
        @(posedge rst_n);
        @(negedge clk);
        check("R1 reset outputs", {fcs_valid, result_valid, check_pass}, 3'b000);
        repeat (3) @(negedge clk);
        check("R1 idle without start", {fcs_valid, result_valid, check_pass}, 3'b000);

        // R9: abandon a frame half way, then restart
        begin_frame(1'b0);
        feed(64'h2D, 4, 1'b0);
        check("R9 mid-emit state", fcs_valid, 1);
        start = 1'b1; rx_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 start clears status", {fcs_valid, result_valid}, 2'b00);
        feed(((64'h5 << W) | model_rem(64'h5, 3)), 3 + W, 1'b0);
        check("R9 restarted rx frame passes", {result_valid, check_pass}, 2'b11);

        for (int n = 0; n < NUM; n++) begin
            m = EXHAUST ? 64'(n) : ({32'($urandom), 32'($urandom)} & ((64'd1 << LEN) - 1));
            tx_frame(m, n[0]);                                 // R3 gaps on odd n
            repeat (2) @(negedge clk);
            check("R8 done holds", result_valid, 1);
            rx_frame(m, -1, n[1]);                             // R2 fresh register
            rx_frame(m, n % (LEN + W), 1'b0);
        end
        done = 1'b1;
    end

endmodule

module serial_crc_engine_tb;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    int   cycles = 0;
    bit   wd_fail = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    crc_cfg_bench #(.W(5), .POLY(5'b10101), .LEN(10), .NUM(1024), .EXHAUST(1'b1)) u_w5 (
        .clk(clk), .rst_n(rst_n)
    );

    crc_cfg_bench #(.W(16), .POLY(16'h1021), .LEN(24), .NUM(300), .EXHAUST(1'b0)) u_w16 (
        .clk(clk), .rst_n(rst_n)
    );

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        wait ((u_w5.done && u_w16.done) || cycles >= 190000);
        if (!(u_w5.done && u_w16.done)) begin
            wd_fail = 1'b1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 u_w5.n_checks + u_w16.n_checks + int'(wd_fail),
                 u_w5.n_fails + u_w16.n_fails + int'(wd_fail));
        $finish;
    end

endmodule